// File: doc/BRIEF.md
# Router Input Switching Controller with Path Locking

This block is the switching controller for the five input ports of a two-dimensional mesh router. The ports are Local, North, East, South and West. Each input shows the flit at the head of its buffer. When that flit is a header, the controller works out the output port from the header's destination coordinates and the router's own coordinates. It uses dimension-ordered routing: X is resolved first, then Y, and a packet whose destination matches this node is delivered to the Local port.

Once an input has won its output port, the path from that input to that output stays locked. Every later flit of the packet takes the same path. The lock is released only when the tail flit has been forwarded. When several inputs want the same free output, each output has its own round-robin arbiter that picks one of them. A downstream link that is not ready stalls the packet in place, and the path stays locked while it waits.

A static parameter selects the switching mode:
- In wormhole mode, the header competes for its output as soon as it reaches the head of the buffer.
- In store-and-forward mode, the header waits until the input buffer reports that the whole packet, up to its tail, has been stored.

The crossbar datapath and the flit storage sit outside this block. The controller drives a pop strobe for each input and a valid and source select for each output.

Top module: `swpl_path_lock`

## Requirements
- R1: After reset, no input is popped, no output is valid and every input is unlocked.
- R2: Port codes are 0 Local, 1 North, 2 East, 3 South and 4 West. If the destination X is greater than the local X, the header is routed East (2). If it is smaller, the header is routed West (4). This holds whatever the Y coordinates are.
- R3: If the destination X equals the local X, the header is routed North (1) when the destination Y is greater than the local Y, and South (3) when it is smaller.
- R4: If both destination coordinates equal the local coordinates, the header is routed to Local (0).
- R5: Flit type codes are 00 header, 01 data, 10 address and 11 tail.
  - A header at an unlocked input that wins its free output locks the path at the next clock edge.
  - From the following cycle onward, each flit at the head of that input is forwarded on the locked output: that output's valid rises, its source select names the input, and the input is popped.
  - In wormhole mode none of this waits for the whole packet to arrive.
- R6: Forwarding a tail flit (11) releases the path at that clock edge. The output is then free for the next header.
- R7: While the locked output's ready line is low, the input is not popped and the output is not valid. The locked route is kept, and forwarding resumes as soon as ready returns.
- R8: Inputs competing for the same free output are served in round-robin order. The search starts just after the input granted last, and the pointer starts at input 0 after reset.
- R9: In store-and-forward mode, a header is not granted while its input reports that the packet is not yet completely buffered. It is granted once that report is high.
- R10: An unlocked input whose head flit is data (01), address (10) or tail (11) is neither popped nor given an output.
- R11: At most one input holds a given output at any time. An input waiting for an output held by another input is not popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_x | input | COORD_W | X coordinate of this router |
| loc_y | input | COORD_W | Y coordinate of this router |
| in_vld | input | 5 | A head flit is present, one bit per input |
| in_kind | input | 10 | 2-bit flit type per input, input i at bits [2i+1:2i] |
| in_dst_x | input | 5*COORD_W | Destination X carried by each input's header |
| in_dst_y | input | 5*COORD_W | Destination Y carried by each input's header |
| in_pkt_done | input | 5 | The input buffer holds the whole packet up to its tail (used in store-and-forward mode) |
| out_ready | input | 5 | Downstream ready, one bit per output |
| in_pop | output | 5 | Head flit of the input is forwarded this cycle |
| in_route | output | 15 | Locked output code per input, 3 bits each |
| out_vld | output | 5 | Flit valid on each output |
| out_src | output | 15 | Source input driving each output, 3 bits each |

## Verification
The assertions check the structural rules on every cycle:
- an output never has two owners;
- a busy output never issues a grant;
- a grant always matches a request;
- a valid output always has ready high;
- a locked route never changes until its tail is forwarded, and the path is gone one cycle after the tail;
- in store-and-forward mode, a lock never begins without the packet-complete report.

Only the bench's scenarios can show the routing decisions for each direction, the fairness order between competing inputs, the one-cycle latency from header to forwarding, and the fact that stray non-header flits are left untouched.

// File: rtl/swpl_pkg.sv
package swpl_pkg;

    localparam int NPORT = 5;
    localparam int PW    = 3;
    localparam int MAXCW = 16;

    typedef enum logic [PW-1:0] {
        P_LOCAL = 3'd0,
        P_NORTH = 3'd1,
        P_EAST  = 3'd2,
        P_SOUTH = 3'd3,
        P_WEST  = 3'd4
    } port_e;

    typedef enum logic [1:0] {
        K_HEAD = 2'b00,
        K_DATA = 2'b01,
        K_ADDR = 2'b10,
        K_TAIL = 2'b11
    } kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } in_state_e;

    // Dimension-ordered decision: X first, then Y, then deliver locally.
    function automatic port_e xy_pick(input logic [MAXCW-1:0] lx,
                                      input logic [MAXCW-1:0] ly,
                                      input logic [MAXCW-1:0] dx,
                                      input logic [MAXCW-1:0] dy);
        port_e p;
        if (dx > lx)      p = P_EAST;
        else if (dx < lx) p = P_WEST;
        else if (dy > ly) p = P_NORTH;
        else if (dy < ly) p = P_SOUTH;
        else              p = P_LOCAL;
        return p;
    endfunction

endpackage

// File: rtl/swpl_input_ctl.sv
module swpl_input_ctl
    import swpl_pkg::*;
#(
    parameter int COORD_W   = 4,
    parameter bit STORE_FWD = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [COORD_W-1:0] lx,
    input  logic [COORD_W-1:0] ly,
    input  logic               vld,
    input  logic [1:0]         kind,
    input  logic [COORD_W-1:0] dx,
    input  logic [COORD_W-1:0] dy,
    input  logic               done,
    input  logic               granted,
    input  logic [NPORT-1:0]   out_ready,
    output logic               req,
    output logic [PW-1:0]      req_port,
    output logic               active,
    output logic [PW-1:0]      route,
    output logic               pop
);

    in_state_e     state_q;
    port_e         route_q;
    port_e         pick;
    kind_e         k;
    logic          hdr_ok;
    logic          is_tail;

    assign k       = kind_e'(kind);
    assign is_tail = (k == K_TAIL);
    assign pick    = xy_pick(MAXCW'(lx), MAXCW'(ly), MAXCW'(dx), MAXCW'(dy));

    generate
        if (STORE_FWD) begin : g_sf
            assign hdr_ok = vld && (k == K_HEAD) && done;
        end else begin : g_wh
            assign hdr_ok = vld && (k == K_HEAD);
        end
    endgenerate

    assign req      = (state_q == ST_IDLE) && hdr_ok;
    assign req_port = pick;
    assign active   = (state_q == ST_HOLD);
    assign route    = route_q;
    assign pop      = active && vld && out_ready[route_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            route_q <= P_LOCAL;
        end else begin
            case (state_q)
                ST_IDLE: if (req && granted) begin
                    state_q <= ST_HOLD;
                    route_q <= pick;
                end
                ST_HOLD: if (pop && is_tail) begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R6: forwarding the tail frees the path at that edge
    assert_tail_release_R6: assert property (@(posedge clk) disable iff (rst)
        (pop && is_tail) |=> !active);

    // R5 / R7: locked route held until the tail leaves
    assert_route_held_R5: assert property (@(posedge clk) disable iff (rst)
        (active && !(pop && is_tail)) |=> (active && $stable(route)));

    // R11: a grant only reaches an input that asked for it
    assert_grant_needs_req_R11: assert property (@(posedge clk) disable iff (rst)
        granted |-> req);

    generate
        if (STORE_FWD) begin : g_sf_chk
            // R9: a lock begins only after the whole packet was reported stored
            assert_sf_wait_R9: assert property (@(posedge clk) disable iff (rst)
                $rose(active) |-> $past(done));
        end
    endgenerate

endmodule

// File: rtl/swpl_rr_arb.sv
module swpl_rr_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         busy,
    output logic [N-1:0] gnt
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr_q;
    logic [IW-1:0] win;
    logic          found;
    int            idx;

    always_comb begin
        gnt   = '0;
        win   = ptr_q;
        found = 1'b0;
        idx   = 0;
        for (int k = 0; k < N; k++) begin
            idx = int'(ptr_q) + k;
            if (idx >= N) idx = idx - N;
            if (!busy && !found && req[idx]) begin
                gnt[idx] = 1'b1;
                win      = IW'(idx);
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (found) begin
            ptr_q <= (win == IW'(N-1)) ? '0 : win + 1'b1;
        end
    end

    // R8 / R11: one winner at most, and only among requesters
    assert_gnt_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    assert_gnt_in_req_R8: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

    // R11: a held output grants nobody
    assert_busy_no_gnt_R11: assert property (@(posedge clk) disable iff (rst)
        busy |-> (gnt == '0));

endmodule

// File: rtl/swpl_out_mux.sv
module swpl_out_mux
    import swpl_pkg::*;
#(
    parameter int N = NPORT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N-1:0]          act,
    input  logic [N-1:0][PW-1:0]  route,
    input  logic [N-1:0]          pop,
    output logic [N-1:0]          out_vld,
    output logic [N-1:0]          busy,
    output logic [N-1:0][PW-1:0]  src
);

    logic [N-1:0][N-1:0] own;

    always_comb begin
        for (int o = 0; o < N; o++) begin
            for (int i = 0; i < N; i++) begin
                own[o][i] = act[i] && (route[i] == PW'(o));
            end
        end
    end

    always_comb begin
        out_vld = '0;
        busy    = '0;
        src     = '0;
        for (int o = 0; o < N; o++) begin
            busy[o] = |own[o];
            for (int i = 0; i < N; i++) begin
                if (own[o][i]) begin
                    src[o]     = PW'(i);
                    out_vld[o] = pop[i];
                end
            end
        end
    end

    generate
        for (genvar o = 0; o < N; o++) begin : g_chk
            // R11: one owner per output
            assert_one_owner_R11: assert property (@(posedge clk) disable iff (rst)
                $onehot0(own[o]));
        end
    endgenerate

endmodule

// File: rtl/swpl_path_lock.sv
module swpl_path_lock
    import swpl_pkg::*;
#(
    parameter int COORD_W   = 4,
    parameter bit STORE_FWD = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [COORD_W-1:0]       loc_x,
    input  logic [COORD_W-1:0]       loc_y,
    input  logic [NPORT-1:0]         in_vld,
    input  logic [NPORT*2-1:0]       in_kind,
    input  logic [NPORT*COORD_W-1:0] in_dst_x,
    input  logic [NPORT*COORD_W-1:0] in_dst_y,
    input  logic [NPORT-1:0]         in_pkt_done,
    input  logic [NPORT-1:0]         out_ready,
    output logic [NPORT-1:0]         in_pop,
    output logic [NPORT*PW-1:0]      in_route,
    output logic [NPORT-1:0]         out_vld,
    output logic [NPORT*PW-1:0]      out_src
);

    logic [NPORT-1:0]              req;
    logic [NPORT-1:0][PW-1:0]      req_port;
    logic [NPORT-1:0]              active;
    logic [NPORT-1:0][PW-1:0]      route;
    logic [NPORT-1:0]              granted;
    logic [NPORT-1:0][NPORT-1:0]   arb_req;
    logic [NPORT-1:0][NPORT-1:0]   arb_gnt;
    logic [NPORT-1:0]              out_busy;
    logic [NPORT-1:0][PW-1:0]      src;

    generate
        for (genvar i = 0; i < NPORT; i++) begin : g_in
            swpl_input_ctl #(
                .COORD_W   (COORD_W),
                .STORE_FWD (STORE_FWD)
            ) u_in (
                .clk       (clk),
                .rst       (rst),
                .lx        (loc_x),
                .ly        (loc_y),
                .vld       (in_vld[i]),
                .kind      (in_kind[2*i +: 2]),
                .dx        (in_dst_x[COORD_W*i +: COORD_W]),
                .dy        (in_dst_y[COORD_W*i +: COORD_W]),
                .done      (in_pkt_done[i]),
                .granted   (granted[i]),
                .out_ready (out_ready),
                .req       (req[i]),
                .req_port  (req_port[i]),
                .active    (active[i]),
                .route     (route[i]),
                .pop       (in_pop[i])
            );
        end
    endgenerate

    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                arb_req[o][i] = req[i] && (req_port[i] == PW'(o));
            end
        end
    end

    generate
        for (genvar o = 0; o < NPORT; o++) begin : g_arb
            swpl_rr_arb #(.N(NPORT)) u_arb (
                .clk  (clk),
                .rst  (rst),
                .req  (arb_req[o]),
                .busy (out_busy[o]),
                .gnt  (arb_gnt[o])
            );
        end
    endgenerate

    always_comb begin
        granted = '0;
        for (int i = 0; i < NPORT; i++) begin
            for (int o = 0; o < NPORT; o++) begin
                granted[i] = granted[i] | arb_gnt[o][i];
            end
        end
    end

    swpl_out_mux #(.N(NPORT)) u_mux (
        .clk     (clk),
        .rst     (rst),
        .act     (active),
        .route   (route),
        .pop     (in_pop),
        .out_vld (out_vld),
        .busy    (out_busy),
        .src     (src)
    );

    assign in_route = route;
    assign out_src  = src;

    // R7: nothing is presented on an output whose downstream is congested
    assert_no_send_congested_R7: assert property (@(posedge clk) disable iff (rst)
        (out_vld & ~out_ready) == '0);

    // R1: no locked path on the first cycle out of reset
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (out_vld == '0 && in_pop == '0));

endmodule

// File: tb/swpl_path_lock_bench.sv
module swpl_path_lock_bench;

    localparam int CW = 4;
    localparam int NP = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [CW-1:0]   loc_x = 4'd2;
    logic [CW-1:0]   loc_y = 4'd2;
    logic [NP-1:0]   in_vld = '0;
    logic [NP*2-1:0] in_kind = '0;
    logic [NP*CW-1:0] in_dst_x = '0;
    logic [NP*CW-1:0] in_dst_y = '0;
    logic [NP-1:0]   in_pkt_done = '0;
    logic [NP-1:0]   out_ready = '1;

    logic [NP-1:0]   in_pop, out_vld, sf_pop, sf_out_vld;
    logic [NP*3-1:0] in_route, out_src, sf_route, sf_out_src;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    swpl_path_lock #(.COORD_W(CW), .STORE_FWD(1'b0)) u_swpl_path_lock (
        .clk(clk), .rst(rst), .loc_x(loc_x), .loc_y(loc_y),
        .in_vld(in_vld), .in_kind(in_kind), .in_dst_x(in_dst_x), .in_dst_y(in_dst_y),
        .in_pkt_done(in_pkt_done), .out_ready(out_ready),
        .in_pop(in_pop), .in_route(in_route), .out_vld(out_vld), .out_src(out_src)
    );

    swpl_path_lock #(.COORD_W(CW), .STORE_FWD(1'b1)) u_swpl_path_lock_sf (
        .clk(clk), .rst(rst), .loc_x(loc_x), .loc_y(loc_y),
        .in_vld(in_vld), .in_kind(in_kind), .in_dst_x(in_dst_x), .in_dst_y(in_dst_y),
        .in_pkt_done(in_pkt_done), .out_ready(out_ready),
        .in_pop(sf_pop), .in_route(sf_route), .out_vld(sf_out_vld), .out_src(sf_out_src)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input int i, input bit v, input logic [1:0] k,
                         input int dx, input int dy, input bit dn);
        in_vld[i]              = v;
        in_kind[2*i +: 2]      = k;
        in_dst_x[CW*i +: CW]   = CW'(dx);
        in_dst_y[CW*i +: CW]   = CW'(dy);
        in_pkt_done[i]         = dn;
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    function automatic int exp_port(input int dx, input int dy);
        if (dx > 2) return 2;
        if (dx < 2) return 4;
        if (dy > 2) return 1;
        if (dy < 2) return 3;
        return 0;
    endfunction

    // header, ndata body flits (alternating data/address), tail on input i
    task automatic run_packet(input int i, input int dx, input int dy,
                              input int ndata, input string tag);
        int ep;
        ep = exp_port(dx, dy);
        step; drive(i, 1'b1, 2'b00, dx, dy, 1'b0); #1;
        chk(in_pop[i] == 1'b0, {tag, " R5 header waits one cycle"}, int'(in_pop[i]), 0);
        step; #1;
        chk(int'(in_route[3*i +: 3]) == ep, {tag, " route"}, int'(in_route[3*i +: 3]), ep);
        chk(out_vld[ep] == 1'b1 && in_pop[i] == 1'b1, {tag, " R5 header forwarded"},
            int'(out_vld[ep]), 1);
        chk(int'(out_src[3*ep +: 3]) == i, {tag, " R5 source select"},
            int'(out_src[3*ep +: 3]), i);
        for (int d = 0; d < ndata; d++) begin
            step; drive(i, 1'b1, (d % 2 == 0) ? 2'b01 : 2'b10, 0, 0, 1'b0); #1;
            chk(in_pop[i] == 1'b1 && out_vld[ep] == 1'b1, {tag, " R5 body flit follows path"},
                int'(in_pop[i]), 1);
        end
        step; drive(i, 1'b1, 2'b11, 0, 0, 1'b0); #1;
        chk(in_pop[i] == 1'b1 && out_vld[ep] == 1'b1, {tag, " R6 tail forwarded"},
            int'(in_pop[i]), 1);
        step; drive(i, 1'b0, 2'b00, 0, 0, 1'b0); #1;
        chk(out_vld == '0, {tag, " R6 path released"}, int'(out_vld), 0);
    endtask

    task automatic t_reset;
        step; #1;
        chk(out_vld == '0 && in_pop == '0, "R1 reset idle", int'(out_vld), 0);
        chk(sf_out_vld == '0 && sf_pop == '0, "R1 reset idle sf", int'(sf_out_vld), 0);
    endtask

    task automatic t_routes;
        run_packet(0, 2, 2, 1, "R4 local");
        run_packet(1, 4, 0, 2, "R2 east x-first");
        run_packet(3, 0, 3, 0, "R2 west x-first");
        run_packet(2, 2, 3, 1, "R3 north");
        run_packet(4, 2, 0, 3, "R3 south");
    endtask

    task automatic t_backpressure;
        step; drive(0, 1'b1, 2'b00, 3, 2, 1'b0);
        step; #1;
        chk(in_pop[0] == 1'b1 && out_vld[2] == 1'b1, "R7 header out", int'(in_pop[0]), 1);
        step; drive(0, 1'b1, 2'b01, 0, 0, 1'b0); out_ready[2] = 1'b0; #1;
        chk(in_pop[0] == 1'b0 && out_vld[2] == 1'b0, "R7 stalled", int'(in_pop[0]), 0);
        step; #1;
        chk(in_pop[0] == 1'b0 && out_vld[2] == 1'b0, "R7 still stalled", int'(in_pop[0]), 0);
        chk(int'(in_route[2:0]) == 2, "R7 route kept", int'(in_route[2:0]), 2);
        step; out_ready[2] = 1'b1; #1;
        chk(in_pop[0] == 1'b1 && out_vld[2] == 1'b1, "R7 resumes", int'(in_pop[0]), 1);
        step; drive(0, 1'b1, 2'b11, 0, 0, 1'b0);
        step; drive(0, 1'b0, 2'b00, 0, 0, 1'b0); #1;
        chk(out_vld == '0, "R6 released after stall", int'(out_vld), 0);
    endtask

    task automatic t_round_robin;
        // arbiters for Local were used once by input 0 (R4 test): pointer now 1
        step; drive(1, 1'b1, 2'b00, 2, 2, 1'b0); drive(2, 1'b1, 2'b00, 2, 2, 1'b0);
        step; #1;
        chk(int'(out_src[2:0]) == 1 && out_vld[0], "R8 first winner input1",
            int'(out_src[2:0]), 1);
        chk(in_pop[2] == 1'b0, "R11 loser not popped", int'(in_pop[2]), 0);
        step; drive(1, 1'b1, 2'b11, 0, 0, 1'b0); #1;
        chk(in_pop[1] == 1'b1 && in_pop[2] == 1'b0, "R11 single owner", int'(in_pop[2]), 0);
        step; drive(1, 1'b1, 2'b00, 2, 2, 1'b0); #1;   // input1 returns at once
        step; #1;
        chk(int'(out_src[2:0]) == 2 && in_pop[2], "R8 rotation to input2",
            int'(out_src[2:0]), 2);
        chk(in_pop[1] == 1'b0, "R8 input1 waits its turn", int'(in_pop[1]), 0);
        step; drive(2, 1'b1, 2'b11, 0, 0, 1'b0);
        step; drive(2, 1'b0, 2'b00, 0, 0, 1'b0);
        step; #1;
        chk(int'(out_src[2:0]) == 1 && in_pop[1], "R8 input1 served next",
            int'(out_src[2:0]), 1);
        step; drive(1, 1'b1, 2'b11, 0, 0, 1'b0);
        step; drive(1, 1'b0, 2'b00, 0, 0, 1'b0); #1;
        chk(out_vld == '0, "R6 all released", int'(out_vld), 0);
    endtask

    task automatic t_ignore;
        step; drive(3, 1'b1, 2'b01, 0, 0, 1'b0);
        for (int c = 0; c < 3; c++) begin
            step; #1;
            chk(in_pop[3] == 1'b0 && out_vld == '0, "R10 stray data ignored", int'(in_pop[3]), 0);
        end
        step; drive(3, 1'b1, 2'b11, 0, 0, 1'b0);
        step; #1;
        chk(in_pop[3] == 1'b0 && out_vld == '0, "R10 stray tail ignored", int'(in_pop[3]), 0);
        step; drive(3, 1'b1, 2'b10, 0, 0, 1'b0);
        step; #1;
        chk(in_pop[3] == 1'b0 && out_vld == '0, "R10 stray address ignored", int'(in_pop[3]), 0);
        step; drive(3, 1'b0, 2'b00, 0, 0, 1'b0);
    endtask

    task automatic t_store_fwd;
        step; drive(4, 1'b1, 2'b00, 2, 4, 1'b0);
        for (int c = 0; c < 3; c++) begin
            step; #1;
            chk(sf_pop[4] == 1'b0 && sf_out_vld == '0, "R9 header held until stored",
                int'(sf_pop[4]), 0);
        end
        step; in_pkt_done[4] = 1'b1; #1;
        chk(sf_pop[4] == 1'b0, "R9 grant registered first", int'(sf_pop[4]), 0);
        step; #1;
        chk(sf_pop[4] == 1'b1 && sf_out_vld[1] == 1'b1, "R9 forwarded once stored",
            int'(sf_pop[4]), 1);
        chk(int'(sf_out_src[5:3]) == 4, "R9 source select", int'(sf_out_src[5:3]), 4);
        step; drive(4, 1'b1, 2'b11, 0, 0, 1'b1);
        step; drive(4, 1'b0, 2'b00, 0, 0, 1'b0); #1;
        chk(sf_out_vld == '0, "R9 released after tail", int'(sf_out_vld), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_routes;
        t_backpressure;
        t_round_robin;
        t_ignore;
        t_store_fwd;
        step; rst = 1'b1;
        step; rst = 1'b0;
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule